// File: doc/BRIEF.md
# Switchable-Discipline Flit Forwarding Hop

This block is one hop of an on-chip network router. It carries a single upstream input link to a single downstream output link. Incoming flits are held in a local queue, and the block decides in which cycle each flit may leave. A flit is as wide as the link, so every transfer moves one whole flit. A packet is a run of flits that opens with a head flit and closes with a tail flit. The head flit carries the packet's flit count.

A mode input chooses the switching discipline while the hop is idle. In wormhole mode, a flit leaves whenever the downstream buffer has room for that one flit. In cut-through mode, a head flit leaves only once downstream room covers the whole packet, and it may leave before its own tail has arrived. In store-and-forward mode, a head flit waits until its whole packet is held locally and downstream room covers the whole packet.

Downstream room is tracked by a credit counter. The counter starts full, loses one credit for each flit sent and gains one for each pulse on the credit-return input. Once a head flit is sent, the output link stays with that packet until its tail is sent. A head flit whose length the hop cannot hold is discarded together with the rest of its packet, and an error pulse is raised.

Top module: `flit_hop_stage`

## Requirements
- R1: After reset, `out_valid` and `err_o` are 0 and `in_ready` is 1. The credit count equals `DN_DEPTH`, so a full-length packet can leave in cut-through mode without any credit return.
- R2: Wormhole (`sw_mode` 2'b10 or 2'b11). A flit is offered on the output in the cycle after it is accepted, provided at least one credit is held. With no credit the packet stops in place, `out_valid` stays 0 and the link stays reserved.
- R3: Cut-through (`sw_mode` 2'b01). A head flit is not sent while the credit count is below its length field. It is sent in the cycle after the count reaches that length, even when its tail has not yet arrived.
- R4: Store-and-forward (`sw_mode` 2'b00). A head flit is not sent until every flit of its packet is queued locally and the credit count is at least its length. It is first offered in the cycle after its tail is accepted, when credits allow.
- R5: Flits leave in the order they were accepted. Once a head has been sent, only flits of that packet use the link until its tail has been sent.
- R6: Each flit sent costs one credit and each `cred_ret` pulse adds one. A send and a return in the same cycle leave the count unchanged. The count never rises above `DN_DEPTH`, so surplus returns are lost.
- R7: `in_ready` is 0 exactly while the queue holds `BUF_DEPTH` flits. It rises again in the cycle after a flit leaves.
- R8: Flit type is bits [FLIT_W-1:FLIT_W-2] (01 head, 00 body, 10 tail, 11 handled as body), and the head's length field in bits [3:0] counts every flit of the packet. A head whose length is below 2 or above `BUF_DEPTH` raises `err_o` for one cycle in the cycle after it is accepted. That head and every flit up to and including the next tail are accepted and dropped. Later packets are forwarded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_mode | input | 2 | Switching discipline: 00 store-and-forward, 01 cut-through, 1x wormhole |
| in_valid | input | 1 | Upstream flit present |
| in_flit | input | FLIT_W | Upstream flit |
| in_ready | output | 1 | Hop can accept a flit this cycle |
| out_valid | output | 1 | Flit sent downstream this cycle |
| out_flit | output | FLIT_W | Downstream flit |
| cred_ret | input | 1 | One-cycle pulse: downstream freed one slot |
| err_o | output | 1 | One-cycle pulse: packet with an unusable length dropped |

## Verification
A flit send and a credit return can land in the same cycle, and so can a flit arrival and a flit departure in the same cycle. The first case is provoked by pulsing credit returns while an 8-flit packet drains from a nearly exhausted counter. The bench judges it by the exact number of flits that leave: all eight must leave, and a following packet must then find zero credits. The second case occurs throughout the sweep of every length under each discipline, where flits stream in back to back. It is judged by the cycle of the first departure, which is computed from the acceptance cycle of the head or the tail, and by the order of the flits that leave.

// File: rtl/flit_hop_stage.sv
module flit_hop_stage #(
  parameter int FLIT_W    = 16,
  parameter int BUF_DEPTH = 8,
  parameter int DN_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sw_mode,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              in_ready,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit,
  input  logic              cred_ret,
  output logic              err_o
);
  localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int NW = $clog2(BUF_DEPTH + 1);
  localparam int CW = $clog2(DN_DEPTH + 1);
  localparam logic [1:0] M_SAF = 2'b00;
  localparam logic [1:0] M_VCT = 2'b01;
  localparam logic [1:0] T_HEAD = 2'b01;
  localparam logic [1:0] T_TAIL = 2'b10;

  logic [FLIT_W-1:0] mem [BUF_DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [NW-1:0]     count;
  logic [CW-1:0]     cred;
  logic              in_pkt, dropping, err_q;

  wire [1:0] in_type  = in_flit[FLIT_W-1 -: 2];
  wire [3:0] in_len   = in_flit[3:0];
  wire       bad_len  = (in_type == T_HEAD) &&
                        (in_len < 4'd2 || 32'(in_len) > BUF_DEPTH);
  wire       accept   = in_valid && in_ready;
  wire       push     = accept && !dropping && !bad_len;

  wire [FLIT_W-1:0] head_flit = mem[rp];
  wire [3:0]        hd_len    = head_flit[3:0];
  wire              hd_tail   = head_flit[FLIT_W-1 -: 2] == T_TAIL;
  wire              cred_pkt  = 32'(cred) >= 32'(hd_len);

  logic head_ok;
  always_comb begin
    case (sw_mode)
      M_SAF:   head_ok = cred_pkt && 32'(count) >= 32'(hd_len);
      M_VCT:   head_ok = cred_pkt;
      default: head_ok = cred != '0;
    endcase
  end

  wire send = (count != '0) && (in_pkt ? (cred != '0) : head_ok);

  assign in_ready  = count != NW'(BUF_DEPTH);
  assign out_valid = send;
  assign out_flit  = head_flit;
  assign err_o     = err_q;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_flit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      cred     <= CW'(DN_DEPTH);
      in_pkt   <= 1'b0;
      dropping <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (push) wp <= (32'(wp) == BUF_DEPTH - 1) ? '0 : wp + 1'b1;
      if (send) rp <= (32'(rp) == BUF_DEPTH - 1) ? '0 : rp + 1'b1;
      count <= count + NW'(push) - NW'(send);
      if (send) in_pkt <= !hd_tail;
      case ({send, cred_ret})
        2'b10:   cred <= cred - 1'b1;
        2'b01:   if (cred != CW'(DN_DEPTH)) cred <= cred + 1'b1;
        default: cred <= cred;
      endcase
      if (accept) begin
        if (bad_len)                             dropping <= 1'b1;
        else if (dropping && in_type == T_TAIL)  dropping <= 1'b0;
      end
      err_q <= accept && bad_len;
    end
  end
endmodule

// File: rtl/flit_hop_stage_chk.sv
module flit_hop_stage_chk #(
  parameter int FLIT_W    = 16,
  parameter int BUF_DEPTH = 8,
  parameter int DN_DEPTH  = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [1:0]                    sw_mode,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic                          out_valid,
  input logic [FLIT_W-1:0]             out_flit,
  input logic                          cred_ret,
  input logic                          err_o,
  input logic [$clog2(DN_DEPTH+1)-1:0] cred,
  input logic [$clog2(BUF_DEPTH+1)-1:0] count,
  input logic                          in_pkt
);
  // R6
  cred_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cred) <= DN_DEPTH);
  // R6
  cred_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cred_ret |=> 32'(cred) == 32'($past(cred)) - 1);
  // R2
  send_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cred != '0);
  // R3
  vct_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_mode == 2'b01 && out_valid && !in_pkt |-> 32'(cred) >= 32'(out_flit[3:0]));
  // R4
  saf_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_mode == 2'b00 && out_valid && !in_pkt |-> 32'(count) >= 32'(out_flit[3:0]));
  // R5
  link_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !in_pkt |-> out_flit[FLIT_W-1 -: 2] == 2'b01);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= BUF_DEPTH && (in_ready || count != '0));
  // R8
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(in_valid && in_ready));
endmodule

bind flit_hop_stage flit_hop_stage_chk #(
  .FLIT_W(FLIT_W), .BUF_DEPTH(BUF_DEPTH), .DN_DEPTH(DN_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_flit(out_flit),
  .cred_ret(cred_ret), .err_o(err_o), .cred(cred), .count(count),
  .in_pkt(in_pkt)
);

// File: tb/tb_flit_hop_stage.sv
`timescale 1ns/1ps
module tb_flit_hop_stage;
  localparam int FW = 16;
  logic clk = 0, rst_n = 0, in_valid = 0, cred_ret = 0;
  logic [1:0] sw_mode = 2'b10;
  logic [FW-1:0] in_flit = '0;
  logic in_ready, out_valid, err_o;
  logic [FW-1:0] out_flit;

  flit_hop_stage #(.FLIT_W(FW), .BUF_DEPTH(8), .DN_DEPTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .in_valid(in_valid),
    .in_flit(in_flit), .in_ready(in_ready), .out_valid(out_valid),
    .out_flit(out_flit), .cred_ret(cred_ret), .err_o(err_o));

  always #4 clk = ~clk;

  int cyc = 0, ndep = 0, nchk = 0, nerr = 0, tag = 0;
  int dep_cyc [512];
  logic [FW-1:0] dep_f [512];
  logic [FW-1:0] sent_f [512];
  int nsent = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && out_valid) begin
    dep_cyc[ndep] = cyc; dep_f[ndep] = out_flit; ndep++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic send_flit(input logic [FW-1:0] f, output int ac);
    @(negedge clk); in_valid = 1; in_flit = f;
    while (!in_ready) @(negedge clk);
    ac = cyc + 1;
    @(posedge clk); #1 in_valid = 0;
  endtask

  task automatic ret();
    @(negedge clk); cred_ret = 1;
    @(posedge clk); #1 cred_ret = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [FW-1:0] mk(input logic [1:0] t, input logic [3:0] len);
    tag++;
    return {t, 10'(tag), len};
  endfunction

  task automatic send_pkt(input int L, output int hac, output int tac);
    int ac;
    for (int i = 0; i < L; i++) begin
      logic [FW-1:0] f;
      f = (i == 0) ? mk(2'b01, 4'(L)) : mk((i == L-1) ? 2'b10 : 2'b00, 4'd0);
      sent_f[nsent++] = f;
      send_flit(f, ac);
      if (i == 0) hac = ac;
      if (i == L-1) tac = ac;
    end
  endtask

  task automatic chk_order(input int b, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) if (dep_f[b+i] !== sent_f[nsent-n+i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int h, t, b, s, ac, n;
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    // R1 reset values
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    chk(err_o == 0, "R1 err_o", err_o, 0);
    // R1 full credit at reset: 8-flit cut-through packet leaves at once
    sw_mode = 2'b01; b = ndep;
    send_pkt(8, h, t); idle(12);
    chk(dep_cyc[b] == h, "R1 head departure", dep_cyc[b], h);
    chk(ndep - b == 8, "R1 count", ndep - b, 8);

    // sweep of disciplines and lengths with full credit
    for (int m = 0; m < 3; m++) begin
      for (int L = 2; L <= 8; L++) begin
        sw_mode = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b10;
        repeat (8) ret();
        b = ndep; s = nsent;
        send_pkt(L, h, t); idle(12);
        if (m == 0) chk(dep_cyc[b] == t, "R4 waits for tail", dep_cyc[b], t);
        if (m == 1) chk(dep_cyc[b] == h, "R3 leaves before tail", dep_cyc[b], h);
        if (m == 2) chk(dep_cyc[b] == h, "R2 flit leaves next cycle", dep_cyc[b], h);
        chk(ndep - b == L, "R5 all flits leave", ndep - b, L);
        chk_order(b, L, "R5 order");
      end
    end

    // R6 saturation: credits are 0 here; 12 returns must give only 8
    repeat (12) ret();
    sw_mode = 2'b10; b = ndep;
    send_pkt(8, h, t); send_pkt(2, h, t); idle(10);
    chk(ndep - b == 8, "R6 credit cap", ndep - b, 8);
    chk(out_valid == 0, "R2 stall with no credit", out_valid, 0);
    ret(); idle(4);
    chk(ndep - b == 9, "R2 resume one flit", ndep - b, 9);
    ret(); idle(4);
    chk(ndep - b == 10, "R2 resume tail", ndep - b, 10);
    chk_order(b, 10, "R5 order after stall");

    // R3 insufficient credit in cut-through
    sw_mode = 2'b01;
    repeat (3) ret();
    b = ndep; send_pkt(4, h, t); idle(6);
    chk(ndep == b, "R3 held at 3 credits", ndep - b, 0);
    ret(); @(negedge clk);
    chk(out_valid == 1, "R3 leaves when credit reaches length", out_valid, 1);
    idle(8);
    chk(ndep - b == 4, "R3 count", ndep - b, 4);

    // R4 store-and-forward also needs whole-packet credit
    sw_mode = 2'b00;
    repeat (3) ret();
    b = ndep; send_pkt(4, h, t); idle(6);
    chk(ndep == b, "R4 held at 3 credits", ndep - b, 0);
    ret(); idle(8);
    chk(ndep - b == 4, "R4 count", ndep - b, 4);

    // R7 full buffer with no credit
    sw_mode = 2'b10; b = ndep;
    send_pkt(8, h, t); @(negedge clk);
    chk(in_ready == 0, "R7 ready low when full", in_ready, 0);
    idle(2);
    chk(in_ready == 0, "R7 ready stays low", in_ready, 0);
    ret(); @(negedge clk); @(negedge clk);
    chk(in_ready == 1, "R7 ready back after send", in_ready, 1);
    repeat (7) ret(); idle(6);
    chk(ndep - b == 8, "R7 drain", ndep - b, 8);

    // R8 bad lengths
    repeat (8) ret();
    b = ndep;
    send_flit(mk(2'b01, 4'd9), ac);
    chk(err_o == 1, "R8 err on long head", err_o, 1);
    send_flit(mk(2'b00, 4'd0), ac);
    send_flit(mk(2'b10, 4'd0), ac); idle(5);
    chk(ndep == b, "R8 long packet dropped", ndep - b, 0);
    chk(err_o == 0, "R8 err is one pulse", err_o, 0);
    send_flit(mk(2'b01, 4'd1), ac);
    chk(err_o == 1, "R8 err on short head", err_o, 1);
    send_flit(mk(2'b10, 4'd0), ac); idle(5);
    chk(ndep == b, "R8 short packet dropped", ndep - b, 0);
    send_pkt(3, h, t); idle(6);
    chk(ndep - b == 3, "R8 later packet forwarded", ndep - b, 3);
    chk_order(b, 3, "R8 order after drop");

    // R6 returns coinciding with sends: 5 credits + 3 returns = 8 flits
    b = ndep;
    fork
      send_pkt(8, h, t);
      begin @(negedge clk); @(negedge clk); repeat (3) ret(); end
    join
    idle(10);
    chk(ndep - b == 8, "R6 same-cycle return and send", ndep - b, 8);
    b = ndep; send_pkt(2, h, t); idle(6);
    n = ndep - b;
    chk(n == 0, "R6 credits exactly spent", n, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule